// File: doc/BRIEF.md
# Conjugate-Product FM Discriminator

This block turns a complex baseband stream carrying narrow-band FM into audio samples. Each accepted I/Q pair is multiplied by the complex conjugate of the pair accepted just before it. The argument of that product is the phase advance over one sample period, which is proportional to the instantaneous frequency. A sequential CORDIC engine in vectoring mode finds that argument. A decimator then keeps one demodulated value out of every `DECIM`, which brings a 24 ksps input down to 8 ksps audio when `DECIM` is 3.

Both edges of the block use valid/ready streams. An input pair is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while the CORDIC engine holds a sample, and `busy` shows the same condition. An audio word stays on `out_data` until the consumer raises `out_ready`. When a value that must be kept is ready but the output slot is still full, the engine waits and holds its result. Input back-pressure then follows: `in_ready` stays low until the slot drains. A demodulated value that the decimator drops never waits.

Top module: `fm_discriminator`

## Requirements
- R1: An input pair is taken only on an edge where `in_valid` and `in_ready` are both high. After it is taken, `in_ready` is low and `busy` is high for ITER+1 cycles (15 by default), and any `in_valid` during that time has no effect.
- R2: The product is computed as re = M(I,I') + M(Q,Q') and im = M(Q,I') − M(I,Q'). Here (I,Q) is the new pair and (I',Q') is the previous one. M(a,b) is floor(a·b / 32768) clamped to [−32768, 32767], and each sum or difference is clamped to the same range. A pair rotating counter-clockwise gives a positive output.
- R3: Each demodulated value equals atan2(im, re)·32768/π, rounded, within ±8 LSB. It is taken modulo 65536, so +π reads as −32768.
- R4: A product with a negative real part (a phase step beyond ±π/2) is resolved correctly by first rotating it by π, with the sign taken from the imaginary part.
- R5: A product with re = 0 and im = 0 gives exactly 0.
- R6: The previous-sample register is cleared by reset, so the first demodulated value after reset is exactly 0.
- R7: Only the 1st, (DECIM+1)th, (2·DECIM+1)th, … demodulated values after reset reach `out_data`, and none is lost or repeated.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds still. A kept value that finds the slot full stalls the engine and keeps `in_ready` low. With DECIM = 3 and the output blocked from reset, exactly four inputs are taken.
- R9: After reset, `in_ready` is 1 and both `busy` and `out_valid` are 0.
- R10: With the slot free and the value kept, `out_valid` rises on the 15th clock edge after the edge that took the input.
- R11: Full-scale inputs saturate instead of wrapping. Two successive pairs (−32768, 0) give a product of (32767, 0) and an output of 0, not π.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Block can take an input pair this cycle |
| in_i | input | DATA_W | In-phase sample, signed |
| in_q | input | DATA_W | Quadrature sample, signed |
| busy | output | 1 | CORDIC engine holds a sample |
| out_valid | output | 1 | Audio word present |
| out_ready | input | 1 | Consumer takes the audio word |
| out_data | output | DATA_W | Audio sample, signed, ±32768 = ±π per input sample |

## Verification
The bench builds two copies with 16-bit data and 14 CORDIC iterations. One keeps the default DECIM = 3. The other uses DECIM = 1, so every demodulated value is visible and can be compared with an arithmetic model. Both copies get the same stream: 32 phase steps spanning the whole circle at three amplitudes, plus zero, full-scale and negative-axis pairs. This covers every pre-rotation case and every decimation phase. A separate run blocks the DECIM = 3 output from reset and checks the exact stall point.

// File: rtl/fmd_pkg.sv
`timescale 1ns/1ps
package fmd_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_e;

  // atan(2^-idx) expressed in units where pi = 2^19
  function automatic int unsigned atan_step(input int unsigned idx);
    case (idx)
      0:  return 131072;
      1:  return 77376;
      2:  return 40884;
      3:  return 20753;
      4:  return 10417;
      5:  return 5213;
      6:  return 2607;
      7:  return 1304;
      8:  return 652;
      9:  return 326;
      10: return 163;
      11: return 81;
      12: return 41;
      13: return 20;
      14: return 10;
      15: return 5;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/fmd_conj_mult.sv
`timescale 1ns/1ps
module fmd_conj_mult #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic signed [DATA_W-1:0] cur_i,
  input  logic signed [DATA_W-1:0] cur_q,
  output logic signed [DATA_W-1:0] prod_re,
  output logic signed [DATA_W-1:0] prod_im
);
  localparam int PW = 2 * DATA_W;
  localparam logic signed [PW-1:0] PMAX = PW'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] PMIN = -PMAX - PW'(1);
  localparam logic signed [DATA_W-1:0] SMAX = DATA_W'(PMAX);
  localparam logic signed [DATA_W-1:0] SMIN = DATA_W'(PMIN);
  localparam logic signed [DATA_W:0] WMAX = (DATA_W+1)'(SMAX);
  localparam logic signed [DATA_W:0] WMIN = (DATA_W+1)'(SMIN);

  logic signed [DATA_W-1:0] last_i, last_q;

  // fractional multiply: floor(a*b / 2^(DATA_W-1)) with clamp
  function automatic logic signed [DATA_W-1:0] qmul(
    input logic signed [DATA_W-1:0] a,
    input logic signed [DATA_W-1:0] b
  );
    logic signed [PW-1:0] p;
    p = PW'(a) * PW'(b);
    p = p >>> (DATA_W - 1);
    if (p > PMAX)      return SMAX;
    else if (p < PMIN) return SMIN;
    else               return DATA_W'(p);
  endfunction

  function automatic logic signed [DATA_W-1:0] clamp_w(input logic signed [DATA_W:0] s);
    if (s > WMAX)      return SMAX;
    else if (s < WMIN) return SMIN;
    else               return DATA_W'(s);
  endfunction

  logic signed [DATA_W-1:0] m_ii, m_qq, m_qi, m_iq;

  always_comb begin
    m_ii    = qmul(cur_i, last_i);
    m_qq    = qmul(cur_q, last_q);
    m_qi    = qmul(cur_q, last_i);
    m_iq    = qmul(cur_i, last_q);
    prod_re = clamp_w((DATA_W+1)'(m_ii) + (DATA_W+1)'(m_qq));
    prod_im = clamp_w((DATA_W+1)'(m_qi) - (DATA_W+1)'(m_iq));
  end

  // one-sample delay line, cleared so the first product is zero (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_i <= '0;
      last_q <= '0;
    end else if (load) begin
      last_i <= cur_i;
      last_q <= cur_q;
    end
  end

endmodule

// File: rtl/fmd_cordic_atan.sv
`timescale 1ns/1ps
module fmd_cordic_atan
  import fmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ITER   = 14,
  parameter int GUARD  = 4,
  parameter int ZFRAC  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] y_in,
  output logic                     busy,
  output logic                     res_valid,
  input  logic                     res_take,
  output logic signed [DATA_W-1:0] res_angle
);
  localparam int XW    = DATA_W + GUARD + 3;
  localparam int ZW    = DATA_W + ZFRAC + 2;
  localparam int IW    = $clog2(ITER + 1);
  localparam int ZSH   = DATA_W - 1 + ZFRAC - 19;
  localparam int ZSH_L = (ZSH > 0) ? ZSH : 0;
  localparam int ZSH_R = (ZSH < 0) ? -ZSH : 0;
  localparam logic signed [ZW-1:0] ZPI   = ZW'(64'sd1 <<< (DATA_W - 1 + ZFRAC));
  localparam logic signed [ZW-1:0] RND   = ZW'(64'sd1 <<< (ZFRAC - 1));
  localparam logic signed [XW-1:0] RESID = XW'(64'sd1 <<< (GUARD + 5));

  eng_state_e state;
  logic signed [XW-1:0] x, y, x_nx, y_nx, x0, y0, xe, ye, xs, ys;
  logic signed [ZW-1:0] z, z_nx, z0, ang;
  logic [IW-1:0] iter;
  logic zflag;

  // load path: pre-rotate left half-plane vectors by pi (R4)
  always_comb begin
    xe = XW'(x_in) <<< GUARD;
    ye = XW'(y_in) <<< GUARD;
    if (x_in[DATA_W-1]) begin
      x0 = -xe;
      y0 = -ye;
      z0 = y_in[DATA_W-1] ? -ZPI : ZPI;
    end else begin
      x0 = xe;
      y0 = ye;
      z0 = '0;
    end
  end

  // one vectoring micro-rotation per cycle
  always_comb begin
    xs  = x >>> iter;
    ys  = y >>> iter;
    ang = ZW'((atan_step(32'(iter)) << ZSH_L) >> ZSH_R);
    if (!y[XW-1]) begin
      x_nx = x + ys;
      y_nx = y - xs;
      z_nx = z + ang;
    end else begin
      x_nx = x - ys;
      y_nx = y + xs;
      z_nx = z - ang;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      x     <= '0;
      y     <= '0;
      z     <= '0;
      iter  <= '0;
      zflag <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: if (start) begin
          x     <= x0;
          y     <= y0;
          z     <= z0;
          zflag <= (x_in == '0) && (y_in == '0);
          iter  <= '0;
          state <= ENG_RUN;
        end
        ENG_RUN: begin
          x <= x_nx;
          y <= y_nx;
          z <= z_nx;
          if (iter == IW'(ITER - 1)) state <= ENG_DONE;
          else                       iter  <= iter + IW'(1);
        end
        ENG_DONE: if (res_take) state <= ENG_IDLE;
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy      = (state != ENG_IDLE);
  assign res_valid = (state == ENG_DONE);
  // zero vector reports 0 (R5); otherwise round the angle accumulator
  assign res_angle = zflag ? '0 : DATA_W'((z + RND) >>> ZFRAC);

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_right_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_RUN) |-> !x[XW-1]);
  assert_y_converged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((y < RESID) && (y > -RESID)));

endmodule

// File: rtl/fmd_decim.sv
`timescale 1ns/1ps
module fmd_decim #(
  parameter int DATA_W = 16,
  parameter int DECIM  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     res_valid,
  input  logic signed [DATA_W-1:0] res_angle,
  output logic                     res_take,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int CW = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic [CW-1:0] phase;
  logic keep;

  assign keep     = (phase == '0);
  // a dropped value always leaves; a kept one waits for a free slot (R8)
  assign res_take = res_valid && (!keep || !out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (res_take) phase <= (phase == CW'(DECIM - 1)) ? '0 : phase + CW'(1);
      if (res_take && keep) begin
        out_valid <= 1'b1;
        out_data  <= res_angle;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase < CW'(DECIM));
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/fm_discriminator.sv
`timescale 1ns/1ps
module fm_discriminator #(
  parameter int DATA_W = 16,
  parameter int ITER   = 14,
  parameter int DECIM  = 3,
  parameter int GUARD  = 4,
  parameter int ZFRAC  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic                     busy,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data
);
  logic accept, res_valid, res_take;
  logic signed [DATA_W-1:0] prod_re, prod_im, angle;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  fmd_conj_mult #(.DATA_W(DATA_W)) conj_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .cur_i   (in_i),
    .cur_q   (in_q),
    .prod_re (prod_re),
    .prod_im (prod_im)
  );

  fmd_cordic_atan #(
    .DATA_W (DATA_W),
    .ITER   (ITER),
    .GUARD  (GUARD),
    .ZFRAC  (ZFRAC)
  ) cordic_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .x_in      (prod_re),
    .y_in      (prod_im),
    .busy      (busy),
    .res_valid (res_valid),
    .res_take  (res_take),
    .res_angle (angle)
  );

  fmd_decim #(.DATA_W(DATA_W), .DECIM(DECIM)) decim_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_angle (angle),
    .res_take  (res_take),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

endmodule

// File: tb/fm_discriminator_tb_top.sv
`timescale 1ns/1ps
module fm_discriminator_tb_top;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic v1 = 1'b0, v3 = 1'b0, or1 = 1'b1, or3 = 1'b1;
  logic rdy1, rdy3, busy1, busy3, ov1, ov3;
  logic signed [15:0] od1, od3;

  always #2.5 clk = ~clk;

  fm_discriminator #(.DECIM(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v3), .in_ready(rdy3), .in_i(in_i), .in_q(in_q),
    .busy(busy3), .out_valid(ov3), .out_ready(or3), .out_data(od3));

  fm_discriminator #(.DECIM(1)) dut_d1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_ready(rdy1), .in_i(in_i), .in_q(in_q),
    .busy(busy1), .out_valid(ov1), .out_ready(or1), .out_data(od1));

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  bit track = 1'b0;
  int exp1[0:1023]; int tol1[0:1023]; string tag1[0:1023];
  int exp3[0:511];  int tol3[0:511];
  int n_sent = 0, n_exp3 = 0, rcv1 = 0, rcv3 = 0;
  int pi_m = 0, pq_m = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic chk_angle(input int got, input int expv, input int tol, input string tag);
    int d;
    d = (got - expv) & 32'hFFFF;
    if (d >= 32768) d -= 65536;
    check((d <= tol) && (d >= -tol), tag, got, expv);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // R2 model: clamped fractional multiply and clamped sums
  function automatic int clampv(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction
  function automatic int qm(input int a, input int b);
    return clampv((a * b) >>> 15);
  endfunction
  function automatic int exp_angle(input int re, input int im);
    real a;
    if (re == 0 && im == 0) return 0;
    a = $atan2(real'(im), real'(re)) * 32768.0 / PI;
    return $rtoi(a + ((a >= 0.0) ? 0.5 : -0.5));
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; v1 = 1'b0; v3 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input int si, input int sq, input string tag, input int tol);
    int re, im, e, t;
    string tg;
    @(negedge clk);
    while (!(rdy1 && rdy3)) @(negedge clk);
    in_i = 16'(si); in_q = 16'(sq); v1 = 1'b1; v3 = 1'b1;
    re = clampv(qm(si, pi_m) + qm(sq, pq_m));
    im = clampv(qm(sq, pi_m) - qm(si, pq_m));
    e  = exp_angle(re, im);
    t  = (re == 0 && im == 0) ? 0 : tol;
    tg = (tag != "") ? tag : ((re < 0) ? "R4" : "R3");
    exp1[n_sent] = e; tol1[n_sent] = t; tag1[n_sent] = tg;
    if (n_sent % 3 == 0) begin
      exp3[n_exp3] = e; tol3[n_exp3] = t; n_exp3++;
    end
    n_sent++; pi_m = si; pq_m = sq;
    @(negedge clk);
    v1 = 1'b0; v3 = 1'b0;
  endtask

  always @(negedge clk) begin
    if (track && ov1 && or1) begin
      if (rcv1 < n_sent) chk_angle(int'(od1), exp1[rcv1], tol1[rcv1], tag1[rcv1]);
      else check(1'b0, "R7", rcv1, n_sent);
      rcv1++;
    end
    if (track && ov3 && or3) begin
      if (rcv3 < n_exp3) chk_angle(int'(od3), exp3[rcv3], tol3[rcv3], "R7");
      else check(1'b0, "R7", rcv3, n_exp3);
      rcv3++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int k, cnt, nrec;
    int rec[0:7];
    int bi[0:5];
    int bq[0:5];
    bi = '{10000, 0, -10000, 0, 5000, 5000};
    bq = '{0, 10000, 0, -10000, 0, 0};

    do_reset();
    // R9: reset state
    check(rdy3 == 1'b1, "R9", int'(rdy3), 1);
    check(busy3 == 1'b0, "R9", int'(busy3), 0);
    check(ov3 == 1'b0, "R9", int'(ov3), 0);
    check(ov1 == 1'b0 && rdy1 == 1'b1, "R9", int'(ov1), 0);

    // R8: output blocked from reset on the DECIM=3 copy
    or3 = 1'b0; k = 0;
    for (int c = 0; c < 120; c++) begin
      @(negedge clk);
      if (k < 6) begin
        in_i = 16'(bi[k]); in_q = 16'(bq[k]); v3 = 1'b1;
        if (rdy3) k++;
      end
    end
    v3 = 1'b0;
    check(k == 4, "R8", k, 4);            // also R1: held in_valid ignored while busy
    check(rdy3 == 1'b0, "R8", int'(rdy3), 0);
    check(ov3 == 1'b1, "R8", int'(ov3), 1);
    check(od3 == 16'sd0, "R6", int'(od3), 0);
    @(negedge clk);
    check(od3 == 16'sd0 && ov3, "R8", int'(od3), 0);
    or3 = 1'b1; nrec = 0;
    for (int c = 0; c < 40; c++) begin
      if (ov3 && or3 && nrec < 8) begin rec[nrec] = int'(od3); nrec++; end
      @(negedge clk);
    end
    check(nrec == 2, "R8", nrec, 2);
    check(rec[0] == 0, "R6", rec[0], 0);
    chk_angle(rec[1], 16384, 8, "R8");

    // R10 latency on the DECIM=1 copy
    do_reset();
    in_i = 16'sd3000; in_q = -16'sd4000; v1 = 1'b1; v3 = 1'b1;
    @(negedge clk);
    v1 = 1'b0; v3 = 1'b0;
    check(rdy1 == 1'b0 && busy1 == 1'b1, "R1", int'(rdy1), 0);
    cnt = 0;
    while (!ov1 && cnt < 100) begin @(negedge clk); cnt++; end
    check(cnt == 15, "R10", cnt, 15);
    check(od1 == 16'sd0, "R6", int'(od1), 0);
    check(rdy1 == 1'b1, "R1", int'(rdy1), 1);

    // main stream
    do_reset();
    track = 1'b1; n_sent = 0; n_exp3 = 0; rcv1 = 0; rcv3 = 0; pi_m = 0; pq_m = 0;
    send(5000, 7000, "R6", 0);
    send(-32768, 0, "", 8);
    send(-32768, 0, "R11", 8);
    send(0, 0, "R5", 0);
    send(12345, -23456, "R5", 0);
    send(10000, 0, "", 8);
    send(0, 10000, "R2", 8);
    send(20000, 0, "", 8);
    send(-20000, 0, "R4", 8);
    send(32767, 32767, "", 8);
    send(32767, 32767, "R11", 8);
    for (int a = 0; a < 3; a++) begin
      for (int kk = -15; kk <= 16; kk++) begin
        real amp, ph, step;
        amp  = (a == 0) ? 12000.0 : ((a == 1) ? 20000.0 : 32000.0);
        step = real'(kk) * PI / 16.0;
        ph   = 0.37 * real'(kk + 20) + real'(a);
        for (int s = 0; s < 6; s++) begin
          send($rtoi(amp * $cos(ph)), $rtoi(amp * $sin(ph)), "", 8);
          ph = ph + step;
        end
      end
    end
    repeat (60) @(negedge clk);
    check(rcv1 == n_sent, "R7", rcv1, n_sent);
    check(rcv3 == n_exp3, "R7", rcv3, n_exp3);
    summary();
  end

endmodule